// File: doc/BRIEF.md
# SPI Sub Interface with Receive Queue and Interrupt Flags

This block is the serial receive/transmit engine of a peripheral that answers an SPI host in clock mode 0 (clock idles low, data sampled on the rising edge, changed on the falling edge, most significant bit first). The select, clock and data inputs are brought into the system clock domain through two-flop synchronisers. All edge detection then runs on the system clock, so each SCLK high phase and each low phase must last at least three system clock cycles.

A single shift register carries both directions. Each bit shifted in from the host frees one position, and that position shifts the next outgoing bit toward MISO. The outgoing word is taken from a transmit holding register when the block is selected and again after every completed word. Software loads the holding register with a one-cycle strobe. Every completed received word goes into a small first-in first-out queue, which software drains through a show-ahead read port.

Four sticky interrupt flags report word reception, queue overflow, selection and deselection. Software clears them by writing ones to a clear strobe.

Top module: `spi_sub_rxq`

## Requirements
- R1: While the synchronised chip select is high, SCLK edges are ignored: no word completes, no flag other than the deselect flag changes, miso_oe_o is low and miso_o is 0.
- R2: In mode 0 the bit on MOSI is captured at each SCLK rising edge and MISO changes only after a falling edge. Words go most significant bit first, and bit 7 of the outgoing word is on miso_o as soon as the block is selected, before the first clock.
- R3: The outgoing word is the holding register value at selection. After each eighth falling edge the shift register reloads from the holding register, so back-to-back words in one selection each carry the holding value present at that reload.
- R4: Completed words enter a queue of FIFO_DEPTH (4) entries of WORD_W (8) bits and leave it in arrival order. rd_data_o shows the oldest entry while rd_valid_o is 1, and a one-cycle rd_en_i removes it.
- R5: Every completed word sets irq_o[0] (word received).
- R6: A word that completes while the queue holds FIFO_DEPTH entries sets irq_o[1] (overflow). That word is discarded and the queue contents are unchanged.
- R7: The falling edge of chip select sets irq_o[2], and the rising edge sets irq_o[3].
- R8: Flags stay set until a 1 is written to the matching bit of irq_clr_i. A flag that is set in the same cycle as its clear stays set.
- R9: Raising chip select resets the bit counter, so a partial word is dropped and the next selection starts a fresh word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Active-low chip select from the host |
| sclk_i | input | 1 | Serial clock from the host |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |
| miso_oe_o | output | 1 | Output enable for miso_o, high only while selected |
| tx_word_i | input | WORD_W | Value for the transmit holding register |
| tx_load_i | input | 1 | Strobe that loads tx_word_i into the holding register |
| rd_en_i | input | 1 | Removes the oldest queued word |
| rd_data_o | output | WORD_W | Oldest queued word |
| rd_valid_o | output | 1 | Queue holds at least one word |
| irq_o | output | 4 | Sticky flags: 0 word, 1 overflow, 2 select, 3 deselect |
| irq_clr_i | input | 4 | Write-one-to-clear strobes for irq_o |

## Verification
A bit counter that slips shows up as received words rotated by one or more places when they are read from the queue. Because of the synchronisers, it also shows up as a wrong MISO bit within about four system cycles of the next falling edge. A wrong queue count appears at the read port as a missing or repeated word, or as an overflow flag that rises early or never rises. Flag errors appear on irq_o three to four cycles after the triggering pin edge, and the bench compares irq_o with its own model after every selection.

// File: rtl/spi_sub_pkg.sv
package spi_sub_pkg;
    localparam int IRQ_W     = 4;
    localparam int IRQ_WORD  = 0;
    localparam int IRQ_OVF   = 1;
    localparam int IRQ_SEL   = 2;
    localparam int IRQ_DESEL = 3;
endpackage

// File: rtl/spi_sub_sync.sv
module spi_sub_sync #(
    parameter int            W       = 3,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: RST_VAL, s2: RST_VAL};
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.s2;
endmodule

// File: rtl/spi_sub_shift.sv
module spi_sub_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sclk_s,
    input  logic         mosi_s,
    input  logic         cs_n_s,
    input  logic [W-1:0] tx_word,
    output logic         miso,
    output logic         word_done,
    output logic [W-1:0] rx_word,
    output logic         cs_fall,
    output logic         cs_rise
);
    localparam int          CW   = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic          sclk_p;
        logic          cs_p;
        logic [W-1:0]  shreg;
        logic          smp;
        logic [CW-1:0] cnt;
        logic          reload;
    } shift_t;

    shift_t st_d, st_q;
    logic   sclk_rise, sclk_fall;

    always_comb begin
        st_d      = st_q;
        word_done = 1'b0;
        sclk_rise = sclk_s & ~st_q.sclk_p;
        sclk_fall = ~sclk_s & st_q.sclk_p;
        cs_fall   = st_q.cs_p & ~cs_n_s;
        cs_rise   = ~st_q.cs_p & cs_n_s;
        rx_word   = {st_q.shreg[W-2:0], mosi_s};

        st_d.sclk_p = sclk_s;
        st_d.cs_p   = cs_n_s;

        if (cs_n_s) begin
            st_d.cnt    = '0;
            st_d.reload = 1'b0;
        end else if (cs_fall) begin
            st_d.shreg  = tx_word;
            st_d.cnt    = '0;
            st_d.reload = 1'b0;
        end else begin
            if (sclk_rise) begin
                st_d.smp = mosi_s;
                if (st_q.cnt == LAST) begin
                    word_done   = 1'b1;
                    st_d.cnt    = '0;
                    st_d.reload = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + CW'(1);
                end
            end
            if (sclk_fall) begin
                if (st_q.reload) begin
                    st_d.shreg  = tx_word;
                    st_d.reload = 1'b0;
                end else begin
                    st_d.shreg = {st_q.shreg[W-2:0], st_q.smp};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sclk_p: 1'b0, cs_p: 1'b1, shreg: '0, smp: 1'b0,
                      cnt: '0, reload: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign miso = st_q.shreg[W-1];
endmodule

// File: rtl/spi_sub_fifo.sv
module spi_sub_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               push_data,
    input  logic                       pop,
    output logic [W-1:0]               rd_data,
    output logic                       not_empty,
    output logic                       full,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [AW-1:0]    PTR_LAST = AW'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wr;
        logic [AW-1:0]           rd;
        logic [CNT_W-1:0]        cnt;
    } fifo_t;

    fifo_t st_d, st_q;
    logic  do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        full    = (st_q.cnt == CNT_MAX);
        do_pop  = pop & (st_q.cnt != '0);
        do_push = push & ~full;
        if (do_push) begin
            st_d.mem[st_q.wr] = push_data;
            st_d.wr = (st_q.wr == PTR_LAST) ? '0 : st_q.wr + AW'(1);
        end
        if (do_pop) begin
            st_d.rd = (st_q.rd == PTR_LAST) ? '0 : st_q.rd + AW'(1);
        end
        st_d.cnt = st_q.cnt + CNT_W'(do_push) - CNT_W'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data   = st_q.mem[st_q.rd];
    assign not_empty = (st_q.cnt != '0);
    assign count     = st_q.cnt;
endmodule

// File: rtl/spi_sub_rxq.sv
module spi_sub_rxq
    import spi_sub_pkg::*;
#(
    parameter int WORD_W     = 8,
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              sclk_i,
    input  logic              mosi_i,
    output logic              miso_o,
    output logic              miso_oe_o,
    input  logic [WORD_W-1:0] tx_word_i,
    input  logic              tx_load_i,
    input  logic              rd_en_i,
    output logic [WORD_W-1:0] rd_data_o,
    output logic              rd_valid_o,
    output logic [IRQ_W-1:0]  irq_o,
    input  logic [IRQ_W-1:0]  irq_clr_i
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    typedef struct packed {
        logic [WORD_W-1:0] tx_hold;
        logic [IRQ_W-1:0]  irq;
    } top_t;

    top_t              st_d, st_q;
    logic [2:0]        pins_s;
    logic              cs_n_s, sclk_s, mosi_s;
    logic              shift_miso, word_done, cs_fall, cs_rise;
    logic [WORD_W-1:0] rx_word;
    logic              fifo_full;
    logic [CNT_W-1:0]  fifo_cnt;
    logic [IRQ_W-1:0]  irq_set;

    spi_sub_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({cs_n_i, mosi_i, sclk_i}),
        .dout (pins_s)
    );
    assign cs_n_s = pins_s[2];
    assign mosi_s = pins_s[1];
    assign sclk_s = pins_s[0];

    spi_sub_shift #(.W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (sclk_s),
        .mosi_s   (mosi_s),
        .cs_n_s   (cs_n_s),
        .tx_word  (st_q.tx_hold),
        .miso     (shift_miso),
        .word_done(word_done),
        .rx_word  (rx_word),
        .cs_fall  (cs_fall),
        .cs_rise  (cs_rise)
    );

    spi_sub_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (word_done),
        .push_data(rx_word),
        .pop      (rd_en_i),
        .rd_data  (rd_data_o),
        .not_empty(rd_valid_o),
        .full     (fifo_full),
        .count    (fifo_cnt)
    );

    always_comb begin
        st_d               = st_q;
        irq_set            = '0;
        irq_set[IRQ_WORD]  = word_done;
        irq_set[IRQ_OVF]   = word_done & fifo_full;
        irq_set[IRQ_SEL]   = cs_fall;
        irq_set[IRQ_DESEL] = cs_rise;
        st_d.irq           = (st_q.irq & ~irq_clr_i) | irq_set;
        if (tx_load_i) begin
            st_d.tx_hold = tx_word_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign miso_oe_o = ~cs_n_s;
    assign miso_o    = miso_oe_o & shift_miso;
    assign irq_o     = st_q.irq;
endmodule

// File: rtl/spi_sub_rxq_chk.sv
module spi_sub_rxq_chk #(
    parameter int WORD_W     = 8,
    parameter int FIFO_DEPTH = 4
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            cs_n_s,
    input logic                            word_done,
    input logic                            fifo_full,
    input logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_cnt,
    input logic                            rd_en_i,
    input logic                            cs_fall,
    input logic [3:0]                      irq_o,
    input logic [3:0]                      irq_clr_i
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    // R1
    idle_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |-> !word_done);

    // R5
    word_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> irq_o[0]);

    // R6
    ovf_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_done && fifo_full |=> irq_o[1]);

    // R6
    ovf_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_done && fifo_full && !rd_en_i |=> $stable(fifo_cnt));

    // R7
    sel_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> irq_o[2]);

    // R8
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[0] && !irq_clr_i[0] |=> irq_o[0]);

    // R4
    depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CNT_W'(FIFO_DEPTH));
endmodule

bind spi_sub_rxq spi_sub_rxq_chk #(.WORD_W(WORD_W), .FIFO_DEPTH(FIFO_DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n_s   (cs_n_s),
    .word_done(word_done),
    .fifo_full(fifo_full),
    .fifo_cnt (fifo_cnt),
    .rd_en_i  (rd_en_i),
    .cs_fall  (cs_fall),
    .irq_o    (irq_o),
    .irq_clr_i(irq_clr_i)
);

// File: tb/sim_spi_sub_rxq.sv
module sim_spi_sub_rxq;
    localparam int H = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
    logic       miso_o, miso_oe_o;
    logic [7:0] tx_word = '0;
    logic       tx_load = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       rd_valid;
    logic [3:0] irq_o;
    logic [3:0] irq_clr = '0;

    int         checks = 0;
    int         errors = 0;
    logic [7:0] mq[$];
    logic [3:0] mirq = '0;
    logic [7:0] hold_m = '0;
    logic [7:0] exp_tx = '0;

    always #2 clk = ~clk;

    spi_sub_rxq u0 (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .mosi_i(mosi),
        .miso_o(miso_o), .miso_oe_o(miso_oe_o), .tx_word_i(tx_word),
        .tx_load_i(tx_load), .rd_en_i(rd_en), .rd_data_o(rd_data),
        .rd_valid_o(rd_valid), .irq_o(irq_o), .irq_clr_i(irq_clr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] flag_after_word(input logic [3:0] f, input int depth);
        logic [3:0] r = f;
        r[0] = 1'b1;
        if (depth >= 4) r[1] = 1'b1;
        return r;
    endfunction

    task automatic load_tx(input logic [7:0] v);
        @(negedge clk) tx_word = v; tx_load = 1'b1;
        @(negedge clk) tx_load = 1'b0;
        hold_m = v;
    endtask

    task automatic sel();
        @(negedge clk) cs_n = 1'b0;
        mirq[2] = 1'b1;
        exp_tx = hold_m;
        repeat (H) @(negedge clk);
    endtask

    task automatic desel();
        @(negedge clk) cs_n = 1'b1;
        mirq[3] = 1'b1;
        repeat (H) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] m, input string tag);
        logic [7:0] got;
        for (int i = 7; i >= 0; i--) begin
            mosi = m[i];
            repeat (H) @(negedge clk);
            got[i] = miso_o;
            sclk = 1'b1;
            repeat (H) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (H) @(negedge clk);
        chk(tag, got, exp_tx);
        mirq = flag_after_word(mirq, mq.size());
        if (mq.size() < 4) mq.push_back(m);
        exp_tx = hold_m;
    endtask

    task automatic pop_chk(input string tag);
        logic [7:0] e = mq.pop_front();
        @(negedge clk);
        chk({tag, " valid"}, rd_valid, 1);
        chk({tag, " data"}, rd_data, e);
        rd_en = 1'b1;
        @(negedge clk) rd_en = 1'b0;
    endtask

    task automatic clr(input logic [3:0] v);
        @(negedge clk) irq_clr = v;
        @(negedge clk) irq_clr = '0;
        mirq = mirq & ~v;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("reset irq", irq_o, 0);
        chk("reset valid", rd_valid, 0);
        chk("R1 reset oe", miso_oe_o, 0);

        // R1: clocks while deselected are ignored
        mosi = 1'b1;
        for (int i = 0; i < 8; i++) begin
            repeat (H) @(negedge clk) sclk = 1'b1;
            repeat (H) @(negedge clk) sclk = 1'b0;
        end
        repeat (H) @(negedge clk);
        chk("R1 no word", rd_valid, 0);
        chk("R1 no irq", irq_o, 0);
        chk("R1 miso low", {miso_oe_o, miso_o}, 0);

        // R2: first bit visible on selection
        load_tx(8'hC3);
        sel();
        chk("R2 oe", miso_oe_o, 1);
        chk("R2 msb", miso_o, 1);
        chk("R7 select flag", irq_o, 4'b0100);
        xfer(8'h5A, "R2 R3 miso word");
        load_tx(8'h81);
        xfer(8'h3C, "R3 back-to-back");
        xfer(8'hE7, "R3 reload from hold");
        desel();
        chk("R5 R7 flags", irq_o, mirq);
        pop_chk("R4 order 0");
        pop_chk("R4 order 1");
        pop_chk("R4 order 2");
        chk("R4 empty", rd_valid, 0);

        // R8: W1C of one bit leaves the others
        clr(4'b0001);
        chk("R8 partial clear", irq_o, mirq);
        clr(4'b1111);
        chk("R8 full clear", irq_o, 0);

        // R9: partial word dropped
        sel();
        for (int i = 0; i < 3; i++) begin
            mosi = 1'b1;
            repeat (H) @(negedge clk) sclk = 1'b1;
            repeat (H) @(negedge clk) sclk = 1'b0;
        end
        desel();
        chk("R9 no partial", rd_valid, 0);
        sel();
        xfer(8'hA5, "R9 fresh word miso");
        desel();
        pop_chk("R9 fresh word");
        clr(4'b1111);

        // R6: overflow keeps first four
        sel();
        for (int i = 0; i < 6; i++) xfer(8'(8'h10 + i), "R6 miso");
        desel();
        chk("R6 overflow flag", irq_o, mirq);
        for (int i = 0; i < 4; i++) pop_chk("R6 kept");
        chk("R6 dropped", rd_valid, 0);
        clr(4'b1111);

        // random traffic
        for (int it = 0; it < 40; it++) begin
            int nb = 1 + int'($urandom_range(2));
            if ($urandom_range(1) == 1) load_tx(8'($urandom));
            sel();
            for (int b = 0; b < nb; b++) begin
                if ($urandom_range(2) == 0) load_tx(8'($urandom));
                xfer(8'($urandom), "R3 random miso");
            end
            desel();
            chk("R5 R6 R7 random flags", irq_o, mirq);
            while (mq.size() > int'($urandom_range(3))) pop_chk("R4 random");
            clr(4'($urandom));
            chk("R8 random clear", irq_o, mirq);
        end
        while (mq.size() > 0) pop_chk("R4 drain");
        chk("R4 drained", rd_valid, 0);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule